// File: doc/BRIEF.md
# Load/Store Byte-Order and Sign-Extension Formatter

This block is the data formatter that sits between a load/store unit and its memory port. It has two independent paths. The load path takes raw read data from memory, optionally reverses its byte order over the width of the access, and then optionally sign-extends the result to a 64-bit register value. The store path takes a 64-bit register operand and optionally reverses its byte order over the width of the access before the word is handed to memory. A store is therefore formatted before memory sees it, and a load after memory returns it.

Both paths share the access length, given as a byte count, and the reverse flag of the operation in flight. Only the load path reads the sign-extend flag. The block holds no state. Every output is a pure function of the present inputs.

Top module: `ldst_data_fmt`

## Requirements
- R1: With `swap_en` = 0 the store output equals `reg_st_data`, and with `swap_en` = 0 and `sext_en` = 0 the load result equals `mem_rd_data`.
- R2: With `swap_en` = 1 and `acc_len` (binary byte count) equal to 2, 4 or 8, output byte i (bits 8i+7:8i) equals input byte n-1-i for i < n, and every byte at or above n is zero. This applies on both paths.
- R3: With `swap_en` = 1 and `acc_len` = 1, all 64 bits pass through unchanged.
- R4: With `swap_en` = 1 and `acc_len` not in {1, 2, 4, 8}, all 64 bits pass through unchanged.
- R5: On the load path, sign extension acts on the byte-reversed value and not on the raw memory data.
- R6: `sext_en` has no effect on `st_mem_data`.
- R7: With `sext_en` = 1 and `acc_len` = 2, load bits 15:0 are the formatted value and bits 63:16 all copy bit 15.
- R8: With `sext_en` = 1 and `acc_len` other than 2, load bits 31:0 are the formatted value and bits 63:32 all copy bit 31.
- R9: With `sext_en` = 0, the load result is the (possibly reversed) data with no extension.
- R10: Both paths are combinational. Outputs follow inputs within the same cycle, and all-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_rd_data | input | 64 | Raw data returned by the memory port for a load |
| reg_st_data | input | 64 | Register operand to be stored |
| acc_len | input | 4 | Access length in bytes (binary: 1, 2, 4 or 8) |
| swap_en | input | 1 | Reverse the byte order over the access length |
| sext_en | input | 1 | Sign-extend the load result |
| ld_result | output | 64 | Register-ready load value |
| st_mem_data | output | 64 | Data word presented to the memory port |

## Verification
The bench sweeps all sixteen length codes against both flag values. This separates the three supported reversal widths from the identity length and from unsupported codes, and on loads it separates 16-bit extension from 32-bit extension. Each combination is driven with fixed patterns and random words. Patterns with bit 15, bit 31 or bit 63 set show whether extension copies the right bit. Asymmetric byte patterns show whether extension reads the swapped data or the raw data, and whether reversal clears the upper lanes. Because the store operand differs from the load data in every trial, crossing of the two paths is also detected.

// File: rtl/ldfmt_pkg.sv
// Shared widths and length codes for the load/store data formatter.
// Assumes byte-addressed data words whose width is a power-of-two number of bytes.
package ldfmt_pkg;
    localparam int DATA_W  = 64;
    localparam int LEN_W   = 4;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 32;
    localparam int NBYTES  = DATA_W / 8;
    localparam int NSIZES  = $clog2(NBYTES);
    localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(HALF_W / 8);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
endpackage

// File: rtl/ldfmt_lane_swap.sv
// Byte-lane reversal sized by an access length in bytes.
// For a supported power-of-two length n > 1, the low n bytes are mirrored and
// the upper bytes are cleared. Length 1, unsupported lengths, and a clear
// enable all pass the word through untouched. Purely combinational.
module ldfmt_lane_swap
    import ldfmt_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] din,
    input  logic [LEN_W-1:0] len,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);
    localparam int NB  = WIDTH / 8;
    localparam int NSZ = $clog2(NB);

    logic [NSZ:1][WIDTH-1:0] cand;

    // One mirrored candidate per supported size 2, 4, ..., NB.
    for (genvar g = 1; g <= NSZ; g++) begin : gen_sz
        localparam int SZ = 1 << g;
        for (genvar b = 0; b < NB; b++) begin : gen_byte
            if (b < SZ) begin : gen_take
                assign cand[g][8*b +: 8] = din[8*(SZ-1-b) +: 8];
            end else begin : gen_zero
                assign cand[g][8*b +: 8] = 8'h00;
            end
        end
    end

    // Pick the candidate whose size matches the access length; default passes through.
    always_comb begin
        dout = din;
        if (en) begin
            for (int g = 1; g <= NSZ; g++) begin
                if (len == LEN_W'(1 << g)) dout = cand[g];
            end
        end
    end

    // Guard the edge cases of the selector next to it.
    always_comb begin
        // R1
        if (!en) swap_off_pass_chk: assert (dout == din);
        // R3
        if (en && len == LEN_ONE) swap_len1_ident_chk: assert (dout == din);
        // R2
        if (en && len == LEN_HALF)
            swap_half_shape_chk: assert (dout[WIDTH-1:16] == '0 && dout[7:0] == din[15:8]
                                         && dout[15:8] == din[7:0]);
        // R4
        if (en && len == LEN_W'(3)) swap_badlen_pass_chk: assert (dout == din);
    end
endmodule

// File: rtl/ldfmt_sign_widen.sv
// Sign extension for load results. When enabled, a length of two bytes
// extends from bit 15 and any other length extends from bit 31. Assumes the
// input has already been byte-ordered. Purely combinational.
module ldfmt_sign_widen
    import ldfmt_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] din,
    input  logic [LEN_W-1:0] len,
    input  logic             sext,
    output logic [WIDTH-1:0] dout
);
    localparam int UP_H = WIDTH - HALF_W;
    localparam int UP_W = WIDTH - WORD_W;

    // Choose the extension width from the length, or pass through.
    always_comb begin
        if (!sext)
            dout = din;
        else if (len == LEN_HALF)
            dout = {{UP_H{din[HALF_W-1]}}, din[HALF_W-1:0]};
        else
            dout = {{UP_W{din[WORD_W-1]}}, din[WORD_W-1:0]};
    end

    // Upper bits must be uniform and the low part must be kept.
    always_comb begin
        // R7
        if (sext && len == LEN_HALF)
            widen_half_chk: assert (dout[HALF_W-1:0] == din[HALF_W-1:0] &&
                ($countones(dout[WIDTH-1:HALF_W]) == (din[HALF_W-1] ? UP_H : 0)));
        // R8
        if (sext && len != LEN_HALF)
            widen_word_chk: assert (dout[WORD_W-1:0] == din[WORD_W-1:0] &&
                ($countones(dout[WIDTH-1:WORD_W]) == (din[WORD_W-1] ? UP_W : 0)));
        // R9
        if (!sext) widen_off_chk: assert (dout == din);
    end
endmodule

// File: rtl/ldst_data_fmt.sv
// Load/store data formatter. The load path reverses the memory data and then
// sign-extends it. The store path reverses the register operand before it goes
// to memory. Assumes a single shared length and reverse flag for the operation
// in flight. No state, no clock.
module ldst_data_fmt
    import ldfmt_pkg::*;
(
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [DATA_W-1:0] reg_st_data,
    input  logic [LEN_W-1:0]  acc_len,
    input  logic              swap_en,
    input  logic              sext_en,
    output logic [DATA_W-1:0] ld_result,
    output logic [DATA_W-1:0] st_mem_data
);
    logic [DATA_W-1:0] ld_swapped;

    // Load: reverse after the memory port.
    ldfmt_lane_swap #(.WIDTH(DATA_W)) u_ld_swap (
        .din (mem_rd_data),
        .len (acc_len),
        .en  (swap_en),
        .dout(ld_swapped)
    );

    // Load: extend the reversed value.
    ldfmt_sign_widen #(.WIDTH(DATA_W)) u_ld_widen (
        .din (ld_swapped),
        .len (acc_len),
        .sext(sext_en),
        .dout(ld_result)
    );

    // Store: reverse before the memory port.
    ldfmt_lane_swap #(.WIDTH(DATA_W)) u_st_swap (
        .din (reg_st_data),
        .len (acc_len),
        .en  (swap_en),
        .dout(st_mem_data)
    );

    // Ordering and path-separation checks across the submodules.
    always_comb begin
        // R5
        if (swap_en && sext_en && acc_len == LEN_HALF)
            swap_then_extend_chk: assert (ld_result[15:0] == {mem_rd_data[7:0], mem_rd_data[15:8]}
                                          && ld_result[DATA_W-1] == mem_rd_data[7]);
        // R1
        if (!swap_en) store_pass_chk: assert (st_mem_data == reg_st_data);
    end
endmodule

// File: tb/sim_ldst_data_fmt.sv
module sim_ldst_data_fmt;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic [63:0] mem_rd_data, reg_st_data, ld_result, st_mem_data;
    logic [3:0]  acc_len;
    logic        swap_en, sext_en;
    int          checks = 0, errors = 0, cyc = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_data_fmt u0 (
        .mem_rd_data(mem_rd_data), .reg_st_data(reg_st_data), .acc_len(acc_len),
        .swap_en(swap_en), .sext_en(sext_en),
        .ld_result(ld_result), .st_mem_data(st_mem_data)
    );

    // Expected reversal: mirror the low n bytes, clear the rest, for n in {2,4,8}.
    function automatic logic [63:0] exp_swap(input logic [63:0] d, input int n, input bit en);
        logic [63:0] r;
        if (!en || !(n == 2 || n == 4 || n == 8)) return d;
        r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(n-1-i) +: 8];
        return r;
    endfunction

    // Expected extension computed arithmetically as a two's complement value.
    function automatic logic [63:0] exp_ext(input logic [63:0] v, input int n, input bit sx);
        longint unsigned low;
        if (!sx) return v;
        if (n == 2) begin
            low = longint'(v[15:0]);
            return (low >= 64'd32768) ? low - 64'd65536 : low;
        end
        low = longint'(v[31:0]);
        return (low >= 64'd2147483648) ? low - 64'd4294967296 : low;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s len=%0d swap=%0b sext=%0b act=%h exp=%h",
                     tag, acc_len, swap_en, sext_en, act, exp);
        end
    endtask

    // Drive at a rising edge, sample at the following falling edge (same cycle: R10).
    task automatic trial(input logic [63:0] ld_d, input logic [63:0] st_d,
                         input int n, input bit sw, input bit sx);
        string lt, st;
        @(posedge clk);
        mem_rd_data = ld_d; reg_st_data = st_d; acc_len = 4'(n); swap_en = sw; sext_en = sx;
        @(negedge clk);
        if (!sw)                                  st = "R1";
        else if (n == 1)                          st = "R3";
        else if (n == 2 || n == 4 || n == 8)      st = "R2";
        else                                      st = "R4";
        if (sx) lt = (n == 2) ? "R7" : "R8";
        else    lt = sw ? {"R9/", st} : "R1";
        if (sx && sw) lt = {lt, "/R5"};
        check({"load ", lt}, ld_result, exp_ext(exp_swap(ld_d, n, sw), n, sx));
        check({"store ", st, sx ? "/R6" : ""}, st_mem_data, exp_swap(st_d, n, sw));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [8];
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'hFEDC_BA98_7654_3210;
        pats[2] = 64'h0000_0000_0000_80FF;
        pats[3] = 64'h0000_0000_8000_00FF;
        pats[4] = 64'hFF00_0000_0000_0080;
        pats[5] = 64'h8000_0000_0000_0000;
        pats[6] = {$urandom, $urandom};
        pats[7] = {$urandom, $urandom} | 64'h8000_8000_8000_8000;

        // R10: all-zero inputs settle to all-zero outputs.
        mem_rd_data = '0; reg_st_data = '0; acc_len = '0; swap_en = 0; sext_en = 0;
        @(negedge clk);
        check("R10 zero load", ld_result, 64'h0);
        check("R10 zero store", st_mem_data, 64'h0);

        for (int n = 0; n < 16; n++)
            for (int sw = 0; sw < 2; sw++)
                for (int sx = 0; sx < 2; sx++)
                    for (int p = 0; p < 8; p++)
                        trial(pats[p], ~pats[(p + 3) % 8] ^ 64'h5A, n, bit'(sw), bit'(sx));

        // Extra random sweep over supported lengths.
        for (int k = 0; k < 200; k++)
            trial({$urandom, $urandom}, {$urandom, $urandom},
                  1 << ($urandom % 4), bit'($urandom % 2), bit'($urandom % 2));

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule